// File: doc/BRIEF.md
# CAN Transmit Buffer Abort Controller

This block keeps the status of three transmit message buffers in a CAN controller and runs the handshake for aborting them. Each buffer has four pieces of state: an empty flag, an abort request that software can only set, an abort acknowledge flag and an interrupt enable. Software reaches all of them through a small byte-wide register interface.

The transmit engine reports four kinds of event for each buffer: a frame attempt started, a frame completed successfully, arbitration was lost, or an error occurred. The block uses these events to decide whether a pending abort may be granted. It drives a level-sensitive interrupt when an enabled buffer is empty. It also provides a guard that blocks writes to the data area of any buffer that is currently scheduled.

Software schedules a buffer by clearing its empty flag. It can request an abort at any time while the buffer is scheduled. The buffer becomes empty again when the frame succeeds or when an abort is granted, and the acknowledge flag tells software which of the two happened.

Top module: `can_tx_abort_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x00 and the flag register (address 1) reads 0x07: all empty flags are 1 and all acknowledge flags are 0.
- R2: The control register holds abort requests for buffers 2..0 in bits 6..4 and interrupt enables for buffers 2..0 in bits 2..0. Bits 7 and 3 read 0. A control write loads the enables from bits 2..0.
- R3: Writing 1 to an abort bit sets it only if that buffer is scheduled (empty flag 0). Writing 0 never clears a pending abort request.
- R4: If a pending abort targets a scheduled buffer whose frame has not started, the abort is granted at the next clock edge. The grant sets the buffer's empty flag and its acknowledge flag (flag register bits 6..4).
- R5: Once a frame has started, a pending abort waits until the attempt ends. Lost arbitration or an error then grants it. If the attempt fails and no abort is pending, the buffer stays scheduled.
- R6: A successful completion sets the empty flag and leaves the acknowledge flag 0, even when an abort is pending.
- R7: An abort request clears in the same cycle in which its buffer's empty flag becomes set.
- R8: Writing 1 to bit x of the flag register (bits 2..0) schedules buffer x: its empty flag and its acknowledge flag both clear.
- R9: The command register (address 2, reads 0) schedules buffers through bits 2..0 and requests aborts through bits 6..4 in a single write. If one write does both for the same buffer, the schedule takes effect, the abort is ignored, and proto_viol pulses. Any register write with bit 7 or bit 3 set also pulses proto_viol.
- R10: irq is high exactly when some buffer has both its empty flag and its interrupt enable set.
- R11: While soft_rst is high, the control and flag registers are held at their reset values and writes to them have no effect.
- R12: A data write request to a buffer is passed on through buf_wr_ok only when that buffer is empty. A request to a scheduled buffer is blocked and raises buf_wr_viol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Soft reset: holds the registers at their reset values |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 flag, 2 command |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| tx_start | input | 3 | Per-buffer pulse: frame attempt started |
| tx_ok | input | 3 | Per-buffer pulse: frame sent successfully |
| tx_lost_arb | input | 3 | Per-buffer pulse: arbitration lost |
| tx_err | input | 3 | Per-buffer pulse: transmit error |
| buf_wr_req | input | 3 | Per-buffer data write request |
| buf_wr_ok | output | 3 | Data write allowed |
| buf_wr_viol | output | 1 | A data write to a scheduled buffer was blocked |
| proto_viol | output | 1 | Software protocol violation on this register write |
| irq | output | 1 | Transmit-empty interrupt, level |

## Verification
Some invariants are checked by assertions on every cycle:
- an empty buffer never carries an abort request;
- an acknowledge never appears without the empty flag;
- a pending request survives until its buffer empties;
- a successful frame never yields an acknowledge;
- soft reset holds all state at its reset values.

Other behaviours depend on the order of events, so only the bench's directed scenarios can show them:
- the grant timing for an idle buffer compared with a started one;
- a failed attempt that keeps the buffer scheduled;
- the conflicting command write;
- the register bit layout seen by software.

// File: rtl/can_txab_pkg.sv
package can_txab_pkg;
  parameter int NBUF = 3;
  localparam int REG_W   = 8;
  localparam int ABT_LSB = 4;
  localparam int BUF_LSB = 0;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_FLAG = 2'd1,
    ADDR_CMD  = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/can_txab_regif.sv
module can_txab_regif
  import can_txab_pkg::*;
#(
  parameter int N = NBUF
) (
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  input  logic [N-1:0]     txe_vec,
  input  logic [N-1:0]     ack_vec,
  input  logic [N-1:0]     abtrq_vec,
  input  logic [N-1:0]     ie_vec,
  output logic [N-1:0]     sched_vec,
  output logic [N-1:0]     abort_set_vec,
  output logic             ie_we,
  output logic [N-1:0]     ie_wdata,
  output logic             proto_viol,
  output logic [REG_W-1:0] reg_rdata
);
  logic [N-1:0] wd_buf;
  logic [N-1:0] wd_abt;
  logic         wd_rsvd;
  logic         wr_ctrl, wr_flag, wr_cmd;

  assign wd_buf  = reg_wdata[BUF_LSB +: N];
  assign wd_abt  = reg_wdata[ABT_LSB +: N];
  assign wd_rsvd = reg_wdata[7] | reg_wdata[3];

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == ADDR_CTRL);
    wr_flag = reg_wr && (reg_addr == ADDR_FLAG);
    wr_cmd  = reg_wr && (reg_addr == ADDR_CMD);
  end

  always_comb begin
    sched_vec     = '0;
    abort_set_vec = '0;
    if (wr_flag || wr_cmd) sched_vec = wd_buf;
    if (wr_ctrl)           abort_set_vec = wd_abt;
    else if (wr_cmd)       abort_set_vec = wd_abt & ~wd_buf;
  end

  assign ie_we      = wr_ctrl;
  assign ie_wdata   = wd_buf;
  assign proto_viol = (wr_cmd && |(wd_abt & wd_buf)) || (reg_wr && wd_rsvd);

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADDR_CTRL: begin
        reg_rdata[ABT_LSB +: N] = abtrq_vec;
        reg_rdata[BUF_LSB +: N] = ie_vec;
      end
      ADDR_FLAG: begin
        reg_rdata[ABT_LSB +: N] = ack_vec;
        reg_rdata[BUF_LSB +: N] = txe_vec;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/can_txab_slot.sv
module can_txab_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic sched,
  input  logic abort_set,
  input  logic ie_we,
  input  logic ie_wdata,
  input  logic ev_start,
  input  logic ev_ok,
  input  logic ev_fail,
  output logic txe,
  output logic ack,
  output logic abtrq,
  output logic ie
);
  logic txe_d, ack_d, abtrq_d, ie_d, busy, busy_d;
  logic grant, set_evt;

  always_comb begin
    grant   = !txe && abtrq && ((busy && ev_fail) || (!busy && !ev_start));
    set_evt = !txe && (ev_ok || grant);

    txe_d   = txe;
    ack_d   = ack;
    busy_d  = busy;
    abtrq_d = abtrq;
    ie_d    = ie_we ? ie_wdata : ie;

    if (txe) begin
      if (sched) begin
        txe_d = 1'b0;
        ack_d = 1'b0;
      end
    end else begin
      if (ev_start)              busy_d = 1'b1;
      if (ev_ok || ev_fail)      busy_d = 1'b0;
      if (abort_set)             abtrq_d = 1'b1;
      if (set_evt) begin
        txe_d   = 1'b1;
        ack_d   = !ev_ok;
        abtrq_d = 1'b0;
        busy_d  = 1'b0;
      end
    end

    if (soft_rst) begin
      txe_d   = 1'b1;
      ack_d   = 1'b0;
      abtrq_d = 1'b0;
      ie_d    = 1'b0;
      busy_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe   <= 1'b1;
      ack   <= 1'b0;
      abtrq <= 1'b0;
      ie    <= 1'b0;
      busy  <= 1'b0;
    end else begin
      txe   <= txe_d;
      ack   <= ack_d;
      abtrq <= abtrq_d;
      ie    <= ie_d;
      busy  <= busy_d;
    end
  end

  AST_EMPTY_NO_ABTRQ: assert property (@(posedge clk) disable iff (!rst_n)
    txe |-> !abtrq); // R7
  AST_ACK_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> txe); // R4
  AST_ABTRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    abtrq |=> (abtrq || txe)); // R3
  AST_OK_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (ev_ok && !txe) |=> (txe && !ack)); // R6
endmodule

// File: rtl/can_tx_abort_ctrl.sv
module can_tx_abort_ctrl
  import can_txab_pkg::*;
#(
  parameter int N = NBUF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic [N-1:0]     tx_start,
  input  logic [N-1:0]     tx_ok,
  input  logic [N-1:0]     tx_lost_arb,
  input  logic [N-1:0]     tx_err,
  input  logic [N-1:0]     buf_wr_req,
  output logic [N-1:0]     buf_wr_ok,
  output logic             buf_wr_viol,
  output logic             proto_viol,
  output logic             irq
);
  logic [N-1:0] txe_vec, ack_vec, abtrq_vec, ie_vec;
  logic [N-1:0] sched_vec, abort_set_vec, ie_wdata;
  logic         ie_we;

  can_txab_regif #(.N(N)) u_regif (
    .reg_wr        (reg_wr),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .txe_vec       (txe_vec),
    .ack_vec       (ack_vec),
    .abtrq_vec     (abtrq_vec),
    .ie_vec        (ie_vec),
    .sched_vec     (sched_vec),
    .abort_set_vec (abort_set_vec),
    .ie_we         (ie_we),
    .ie_wdata      (ie_wdata),
    .proto_viol    (proto_viol),
    .reg_rdata     (reg_rdata)
  );

  for (genvar i = 0; i < N; i++) begin : g_slot
    can_txab_slot u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .soft_rst  (soft_rst),
      .sched     (sched_vec[i]),
      .abort_set (abort_set_vec[i]),
      .ie_we     (ie_we),
      .ie_wdata  (ie_wdata[i]),
      .ev_start  (tx_start[i]),
      .ev_ok     (tx_ok[i]),
      .ev_fail   (tx_lost_arb[i] | tx_err[i]),
      .txe       (txe_vec[i]),
      .ack       (ack_vec[i]),
      .abtrq     (abtrq_vec[i]),
      .ie        (ie_vec[i])
    );
  end

  assign buf_wr_ok   = buf_wr_req & txe_vec;
  assign buf_wr_viol = |(buf_wr_req & ~txe_vec);
  assign irq         = |(txe_vec & ie_vec);

  AST_SOFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (txe_vec == '1 && ack_vec == '0 && abtrq_vec == '0 && ie_vec == '0)); // R11
  AST_GUARD_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr_ok & ~buf_wr_req) == '0); // R12
endmodule

// File: tb/tb_can_tx_abort_ctrl.sv
module tb_can_tx_abort_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'd0;
  logic [7:0] reg_rdata;
  logic [2:0] tx_start = '0, tx_ok = '0, tx_lost_arb = '0, tx_err = '0;
  logic [2:0] buf_wr_req = '0;
  logic [2:0] buf_wr_ok;
  logic       buf_wr_viol, proto_viol, irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  can_tx_abort_ctrl dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_start(tx_start), .tx_ok(tx_ok), .tx_lost_arb(tx_lost_arb), .tx_err(tx_err),
    .buf_wr_req(buf_wr_req), .buf_wr_ok(buf_wr_ok), .buf_wr_viol(buf_wr_viol),
    .proto_viol(proto_viol), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ev(ref logic [2:0] sig, input logic [2:0] v);
    @(negedge clk);
    sig = v;
    @(negedge clk);
    sig = '0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
    rd(2'd1, d); chk("R1 flag", d, 8'h07);
    chk("R10 irq idle", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_layout();
    logic [7:0] d;
    wr(2'd0, 8'h77);
    rd(2'd0, d); chk("R2 R3 layout, abort ignored when empty", d, 8'h07);
    chk("R10 irq enabled", {7'd0, irq}, 8'h01);
    wr(2'd0, 8'h00);
  endtask

  task automatic t_abort_idle();
    logic [7:0] d;
    wr(2'd1, 8'h01);
    rd(2'd1, d); chk("R8 schedule", d, 8'h06);
    wr(2'd0, 8'h10);
    rd(2'd0, d); chk("R3 abort set", d, 8'h10);
    @(negedge clk);
    rd(2'd1, d); chk("R4 idle grant", d, 8'h17);
    rd(2'd0, d); chk("R7 abort cleared", d, 8'h00);
  endtask

  task automatic t_abort_started();
    logic [7:0] d;
    wr(2'd1, 8'h02);
    ev(tx_start, 3'b010);
    wr(2'd0, 8'h20);
    wr(2'd0, 8'h00);
    rd(2'd0, d); chk("R3 abort sticky", d, 8'h20);
    rd(2'd1, d); chk("R5 held while started", d, 8'h15);
    ev(tx_lost_arb, 3'b010);
    rd(2'd1, d); chk("R5 lost-arb grant", d, 8'h37);
    rd(2'd0, d); chk("R7 abort cleared", d, 8'h00);
  endtask

  task automatic t_error();
    logic [7:0] d;
    wr(2'd1, 8'h04);
    ev(tx_start, 3'b100);
    ev(tx_err, 3'b100);
    rd(2'd1, d); chk("R5 fail keeps scheduled", d, 8'h33);
    ev(tx_start, 3'b100);
    wr(2'd0, 8'h40);
    rd(2'd1, d); chk("R5 no grant mid-frame", d, 8'h33);
    ev(tx_err, 3'b100);
    rd(2'd1, d); chk("R5 error grant", d, 8'h77);
  endtask

  task automatic t_success();
    logic [7:0] d;
    wr(2'd1, 8'h01);
    rd(2'd1, d); chk("R8 ack cleared", d, 8'h66);
    ev(tx_start, 3'b001);
    wr(2'd0, 8'h10);
    ev(tx_ok, 3'b001);
    rd(2'd1, d); chk("R6 success no ack", d, 8'h67);
    rd(2'd0, d); chk("R6 R7 abort cleared", d, 8'h00);
  endtask

  task automatic t_cmd();
    logic [7:0] d;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 8'h11;
    #1; chk("R9 conflict flagged", {7'd0, proto_viol}, 8'h01);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
    rd(2'd1, d); chk("R9 schedule wins", d, 8'h66);
    rd(2'd0, d); chk("R9 abort ignored", d, 8'h00);
    rd(2'd2, d); chk("R9 cmd reads zero", d, 8'h00);
    wr(2'd2, 8'h10);
    @(negedge clk);
    rd(2'd1, d); chk("R9 cmd abort granted", d, 8'h77);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 8'h80;
    #1; chk("R9 reserved bit flagged", {7'd0, proto_viol}, 8'h01);
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 8'h00;
  endtask

  task automatic t_irq();
    wr(2'd0, 8'h01);
    chk("R10 irq on", {7'd0, irq}, 8'h01);
    wr(2'd1, 8'h01);
    chk("R10 irq off when scheduled", {7'd0, irq}, 8'h00);
    wr(2'd2, 8'h10);
    @(negedge clk);
    chk("R10 irq after abort", {7'd0, irq}, 8'h01);
  endtask

  task automatic t_guard();
    @(negedge clk);
    buf_wr_req = 3'b001; #1;
    chk("R12 pass ok", {5'd0, buf_wr_ok}, 8'h01);
    chk("R12 pass viol", {7'd0, buf_wr_viol}, 8'h00);
    buf_wr_req = '0;
    wr(2'd1, 8'h01);
    buf_wr_req = 3'b001; #1;
    chk("R12 block ok", {5'd0, buf_wr_ok}, 8'h00);
    chk("R12 block viol", {7'd0, buf_wr_viol}, 8'h01);
    buf_wr_req = '0;
  endtask

  task automatic t_soft();
    logic [7:0] d;
    wr(2'd1, 8'h02);
    wr(2'd0, 8'h07);
    @(negedge clk); soft_rst = 1'b1;
    wr(2'd0, 8'h07);
    wr(2'd1, 8'h07);
    rd(2'd0, d); chk("R11 ctrl held", d, 8'h00);
    rd(2'd1, d); chk("R11 flag held", d, 8'h07);
    chk("R11 irq low", {7'd0, irq}, 8'h00);
    @(negedge clk); soft_rst = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_layout();
    t_abort_idle();
    t_abort_started();
    t_error();
    t_success();
    t_cmd();
    t_irq();
    t_guard();
    t_soft();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule